// File: doc/BRIEF.md
# Eight-Bit Compare Timer with Pin Output

An 8-bit up-counter advances on each clock where the count-enable input is high. Each cycle it is compared with two compare registers, A and B. A match on either register can set, clear or invert a single timer output pin. Which of these it does is chosen by a 2-bit action code for each register. The pin reads 0 from reset until the first compare match that causes an action. It also reads 0 whenever both action codes are zero.

A match with register A, and a wrap of the counter from all ones to zero, each set a sticky flag in the status register. Software clears a flag by first reading the status register while the flag is 1, then writing 0 to that bit. Two interrupt request outputs are formed from the flags and the enable bits in a separate enable register.

All registers sit on a simple synchronous bus. A write takes effect at the clock edge. Read data is combinational from the address in the same cycle, and that read cycle is the one that arms a flag for clearing.

Top module: `cmp_timer8`

## Requirements
- R1: The register addresses are: 0 counter, 1 compare A (reset 0xFF), 2 compare B (reset 0xFF), 3 status, 4 interrupt enable. The counter resets to 0. It adds 1 at each edge where cnt_en is 1 and wraps to 0 after 0xFF. A bus write to address 0 loads it, and that load takes precedence over counting.
- R2: In a cycle where cnt_en is 1 and the counter equals compare A, status bit 6 (match flag A) is 1 from the next edge on.
- R3: In a cycle where cnt_en is 1 and the counter is 0xFF, status bit 5 (wrap flag) is 1 from the next edge on.
- R4: A flag bit returns to 0 only when two things happen in order: a read of address 3 in a cycle where that bit was 1, then a later write of 0 to that bit. A write of 0 without the earlier read leaves the bit at 1.
- R5: Writing 1 to status bit 6 or bit 5 has no effect on the flag.
- R6: If a flag is set by hardware in the same cycle as a clearing write to it, the flag stays 1.
- R7: Status bit 4 always reads 1 and bit 7 always reads 0. Writes to either bit are ignored. Bits 3:0 are the action codes and can be read and written.
- R8: Status bits 3:2 give the action on a match with B, and bits 1:0 give the action on a match with A. The codes are 00 keep, 01 drive 0, 10 drive 1, 11 invert. A match is a cycle where cnt_en is 1 and the counter equals the register, and the pin changes at the next edge.
- R9: When A and B match in the same cycle: if either action is invert, the pin inverts once. Otherwise a non-keep action for B wins over the action for A.
- R10: While status bits 3:0 are all 0, tmr_out is 0. The output state held inside is kept, and it reappears on the pin once any action bit is set again.
- R11: After reset, tmr_out is 0 until the first compare match.
- R12: irq_cmp_a is match flag A AND bit 0 of address 4. irq_wrap is the wrap flag AND bit 1 of address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable for this cycle |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flags for clearing) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| tmr_out | output | 1 | Timer output pin |
| irq_cmp_a | output | 1 | Interrupt request, compare match A |
| irq_wrap | output | 1 | Interrupt request, counter wrap |

## Verification
Five properties are checked on every cycle:
- a match with A sets its flag;
- the all-ones count sets the wrap flag;
- flag A never drops without a status write;
- the counter steps by one when enabled;
- the pin stays low before the first match.

Other behaviours depend on the order of bus operations, and only the bench's scenarios can show them: the read-then-write clearing sequence, a hardware set racing a clearing write, both channels matching in the same cycle with conflicting codes, and a disabled pin that keeps its internal level. A behavioural reference model is compared against the pin, the interrupts and every read on each clock.

// File: rtl/cmp_timer8_pkg.sv
package cmp_timer8_pkg;

   localparam int ADDR_CNT  = 0;
   localparam int ADDR_CMPA = 1;
   localparam int ADDR_CMPB = 2;
   localparam int ADDR_STAT = 3;
   localparam int ADDR_IEN  = 4;

   // status bit positions (software-visible layout)
   localparam int STAT_FLAG_A   = 6;
   localparam int STAT_FLAG_WRP = 5;
   localparam int STAT_ONE      = 4;

   typedef enum logic [1:0] {
      ACT_KEEP = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_FLIP = 2'b11
   } pin_act_e;

   // merge the actions of both channels for one cycle
   function automatic pin_act_e merge_act(input logic hit_a, input logic hit_b,
                                          input pin_act_e act_a, input pin_act_e act_b);
      pin_act_e r;
      r = ACT_KEEP;
      if (hit_a && hit_b) begin
         if (act_a == ACT_FLIP || act_b == ACT_FLIP) r = ACT_FLIP;
         else if (act_b != ACT_KEEP)                 r = act_b;
         else                                        r = act_a;
      end else if (hit_b) begin
         r = act_b;
      end else if (hit_a) begin
         r = act_a;
      end
      return r;
   endfunction

endpackage

// File: rtl/cmp_timer8_count.sv
module cmp_timer8_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt_q,
   output logic         wrap
);
   localparam logic [W-1:0] ONE = W'(1);

   assign wrap = en && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q <= '0;
      else if (ld) cnt_q <= ld_val;
      else if (en) cnt_q <= cnt_q + ONE;
   end
endmodule

// File: rtl/cmp_timer8_match.sv
module cmp_timer8_match #(
   parameter int W   = 8,
   parameter int NCH = 2
) (
   input  logic                    en,
   input  logic [W-1:0]            cnt,
   input  logic [NCH-1:0][W-1:0]   cmp_vals,
   output logic [NCH-1:0]          hit
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign hit[i] = en && (cnt == cmp_vals[i]);
   end
endmodule

// File: rtl/cmp_timer8_flag.sv
module cmp_timer8_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic rd_stat,
   input  logic wr_stat,
   input  logic wr_bit,
   output logic flag_q
);
   logic arm_q;
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (hw_set)                          flag_d = 1'b1;
      else if (wr_stat && !wr_bit && arm_q) flag_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         flag_q <= flag_d;
         if (!flag_d)                arm_q <= 1'b0;
         else if (rd_stat && flag_q) arm_q <= 1'b1;
      end
   end
endmodule

// File: rtl/cmp_timer8_outctl.sv
module cmp_timer8_outctl
   import cmp_timer8_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit_a,
   input  logic       hit_b,
   input  logic [3:0] osel,
   output logic       pin
);
   pin_act_e act;
   logic     lvl_q;

   always_comb act = merge_act(hit_a, hit_b, pin_act_e'(osel[1:0]), pin_act_e'(osel[3:2]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else begin
         unique case (act)
            ACT_LOW:  lvl_q <= 1'b0;
            ACT_HIGH: lvl_q <= 1'b1;
            ACT_FLIP: lvl_q <= ~lvl_q;
            default:  lvl_q <= lvl_q;
         endcase
      end
   end

   assign pin = (|osel) ? lvl_q : 1'b0;
endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
   import cmp_timer8_pkg::*;
#(
   parameter int             W       = 8,
   parameter int             AW      = 3,
   parameter logic [W-1:0]   CMP_RST = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_en,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [W-1:0]  bus_wdata,
   output logic [W-1:0]  bus_rdata,
   output logic          tmr_out,
   output logic          irq_cmp_a,
   output logic          irq_wrap
);
   localparam int NCH = 2;
   localparam int NFL = 2;

   if (W < 8 || W > 16) begin : g_bad_w
      $error("cmp_timer8: W must be 8..16");
   end
   if (AW < 3) begin : g_bad_aw
      $error("cmp_timer8: AW must be at least 3");
   end

   logic                  wr_cnt, wr_stat, rd_stat;
   logic [NCH-1:0]        wr_cmp;
   logic [NCH-1:0][W-1:0] cmp_q;
   logic [3:0]            osel_q;
   logic [1:0]            ien_q;
   logic [W-1:0]          cnt_q;
   logic                  wrap;
   logic [NCH-1:0]        hit;
   logic [NFL-1:0]        fl_set, fl_wbit, fl_q;

   assign wr_cnt    = bus_wr && (bus_addr == AW'(ADDR_CNT));
   assign wr_stat   = bus_wr && (bus_addr == AW'(ADDR_STAT));
   assign rd_stat   = bus_rd && (bus_addr == AW'(ADDR_STAT));
   assign wr_cmp[0] = bus_wr && (bus_addr == AW'(ADDR_CMPA));
   assign wr_cmp[1] = bus_wr && (bus_addr == AW'(ADDR_CMPB));

   for (genvar c = 0; c < NCH; c++) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cmp_q[c] <= CMP_RST;
         else if (wr_cmp[c]) cmp_q[c] <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osel_q <= '0;
         ien_q  <= '0;
      end else begin
         if (wr_stat) osel_q <= bus_wdata[3:0];
         if (bus_wr && bus_addr == AW'(ADDR_IEN)) ien_q <= bus_wdata[1:0];
      end
   end

   cmp_timer8_count #(.W(W)) u_count (
      .clk(clk), .rst_n(rst_n), .en(cnt_en), .ld(wr_cnt),
      .ld_val(bus_wdata), .cnt_q(cnt_q), .wrap(wrap)
   );

   cmp_timer8_match #(.W(W), .NCH(NCH)) u_match (
      .en(cnt_en), .cnt(cnt_q), .cmp_vals(cmp_q), .hit(hit)
   );

   // flag 0: match A, flag 1: wrap
   assign fl_set  = {wrap, hit[0]};
   assign fl_wbit = {bus_wdata[STAT_FLAG_WRP], bus_wdata[STAT_FLAG_A]};

   for (genvar f = 0; f < NFL; f++) begin : g_flag
      cmp_timer8_flag u_flag (
         .clk(clk), .rst_n(rst_n), .hw_set(fl_set[f]), .rd_stat(rd_stat),
         .wr_stat(wr_stat), .wr_bit(fl_wbit[f]), .flag_q(fl_q[f])
      );
   end

   cmp_timer8_outctl u_out (
      .clk(clk), .rst_n(rst_n), .hit_a(hit[0]), .hit_b(hit[1]),
      .osel(osel_q), .pin(tmr_out)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AW'(ADDR_CNT):  bus_rdata = cnt_q;
         AW'(ADDR_CMPA): bus_rdata = cmp_q[0];
         AW'(ADDR_CMPB): bus_rdata = cmp_q[1];
         AW'(ADDR_STAT): begin
            bus_rdata[STAT_FLAG_A]   = fl_q[0];
            bus_rdata[STAT_FLAG_WRP] = fl_q[1];
            bus_rdata[STAT_ONE]      = 1'b1;
            bus_rdata[3:0]           = osel_q;
         end
         AW'(ADDR_IEN):  bus_rdata[1:0] = ien_q;
         default:        bus_rdata = '0;
      endcase
   end

   assign irq_cmp_a = fl_q[0] & ien_q[0];
   assign irq_wrap  = fl_q[1] & ien_q[1];
endmodule

// File: rtl/cmp_timer8_chk.sv
module cmp_timer8_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cnt_en,
   input logic [W-1:0] cnt_q,
   input logic [W-1:0] cmp_a,
   input logic         wr_cnt,
   input logic         wr_stat,
   input logic         flag_a,
   input logic         flag_w,
   input logic [1:0]   hit,
   input logic         tmr_out
);
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    seen_q <= 1'b0;
      else if (|hit) seen_q <= 1'b1;
   end

   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en && !wr_cnt |=> cnt_q == W'($past(cnt_q) + W'(1)));

   assert_match_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en && (cnt_q == cmp_a) |=> flag_a);

   assert_wrap_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en && (&cnt_q) |=> flag_w);

   assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flag_a && !wr_stat |=> flag_a);

   assert_pin_low_before_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> !tmr_out);
endmodule

bind cmp_timer8 cmp_timer8_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_q(cnt_q), .cmp_a(cmp_q[0]),
   .wr_cnt(wr_cnt), .wr_stat(wr_stat), .flag_a(fl_q[0]), .flag_w(fl_q[1]),
   .hit(hit), .tmr_out(tmr_out)
);

// File: tb/tb_cmp_timer8.sv
`timescale 1ns/1ps
module tb_cmp_timer8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_en = 1'b0;
   logic [2:0] addr = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       tmr_out, irq_a, irq_w;

   int n_tests = 0, n_fail = 0, cycles = 0;
   bit chk_on = 1'b0;

   // reference model state
   int m_cnt, m_ca, m_cb, m_os, m_ie, m_fa, m_fw, m_aa, m_aw, m_lvl;

   always #4 clk = ~clk; // 125 MHz

   cmp_timer8 dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(addr),
      .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
      .tmr_out(tmr_out), .irq_cmp_a(irq_a), .irq_wrap(irq_w)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int model_rd(input int a);
      case (a)
         0: return m_cnt;
         1: return m_ca;
         2: return m_cb;
         3: return (m_fa << 6) | (m_fw << 5) | 16 | m_os;
         4: return m_ie;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin : model
      int ha, hb, hw, ws, rs, na, nw, aa, ab, act;
      cycles++;
      if (!rst_n) begin
         m_cnt = 0; m_ca = 255; m_cb = 255; m_os = 0; m_ie = 0;
         m_fa = 0; m_fw = 0; m_aa = 0; m_aw = 0; m_lvl = 0;
      end else begin
         ha = (cnt_en && m_cnt == m_ca) ? 1 : 0;
         hb = (cnt_en && m_cnt == m_cb) ? 1 : 0;
         hw = (cnt_en && m_cnt == 255) ? 1 : 0;
         ws = (wr && addr == 3) ? 1 : 0;
         rs = (rd && addr == 3) ? 1 : 0;
         na = ha ? 1 : ((ws && !wdata[6] && m_aa) ? 0 : m_fa);
         nw = hw ? 1 : ((ws && !wdata[5] && m_aw) ? 0 : m_fw);
         m_aa = (na == 0) ? 0 : ((rs && m_fa) ? 1 : m_aa);
         m_aw = (nw == 0) ? 0 : ((rs && m_fw) ? 1 : m_aw);
         m_fa = na; m_fw = nw;
         aa = m_os & 3; ab = (m_os >> 2) & 3; act = 0;
         if (ha && hb) act = (aa == 3 || ab == 3) ? 3 : (ab != 0 ? ab : aa);
         else if (hb)  act = ab;
         else if (ha)  act = aa;
         if (act == 1) m_lvl = 0;
         else if (act == 2) m_lvl = 1;
         else if (act == 3) m_lvl = 1 - m_lvl;
         if (wr && addr == 0) m_cnt = wdata;
         else if (cnt_en)     m_cnt = (m_cnt + 1) % 256;
         if (wr && addr == 1) m_ca = wdata;
         if (wr && addr == 2) m_cb = wdata;
         if (ws)              m_os = wdata & 15;
         if (wr && addr == 4) m_ie = wdata & 3;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && chk_on) begin
         check("R8 tmr_out", tmr_out, (m_os != 0) ? m_lvl : 0);
         check("R12 irq_cmp_a", irq_a, m_fa & m_ie & 1);
         check("R12 irq_wrap", irq_w, m_fw & (m_ie >> 1) & 1);
         if (rd) check(addr == 3 ? "R4 status read" : "R1 register read", rdata, model_rd(addr));
      end
   end

   always @(posedge clk) if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic op(input bit en, input bit w, input bit r, input int a, input int d);
      @(negedge clk);
      cnt_en = en; wr = w; rd = r; addr = 3'(a); wdata = 8'(d);
   endtask
   task automatic idle(input int n, input bit en);
      for (int i = 0; i < n; i++) op(en, 0, 0, 0, 0);
   endtask
   task automatic wreg(input int a, input int d);
      op(0, 1, 0, a, d);
   endtask
   task automatic rchk(input int a, input int exp, input int mask, input string tag);
      op(0, 0, 1, a, 0);
      #2 check(tag, rdata & mask, exp & mask);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; chk_on = 1'b1;
      // reset state (R1, R7, R11)
      rchk(0, 8'h00, 8'hFF, "R1 counter reset");
      rchk(1, 8'hFF, 8'hFF, "R1 cmpA reset");
      rchk(2, 8'hFF, 8'hFF, "R1 cmpB reset");
      rchk(3, 8'h10, 8'hFF, "R7 status reset");
      rchk(4, 8'h00, 8'hFF, "R12 enable reset");
      #1 check("R11 pin after reset", tmr_out, 0);
      // R7: bit 4 and bit 7 ignore writes, R5 flag ones ignored
      wreg(3, 8'h00); rchk(3, 8'h10, 8'hFF, "R7 write zero");
      wreg(3, 8'hFF); rchk(3, 8'h1F, 8'hFF, "R7 R5 write ones");
      wreg(3, 8'h00);
      // R2 R8: A drives 1, B drives 0; R11 pin low until match
      wreg(1, 5); wreg(2, 10); wreg(3, 8'h06);
      idle(4, 1);
      #1 check("R11 pin before match", tmr_out, 0);
      idle(16, 1);
      idle(1, 0);
      // R4: write 0 without read keeps flag
      wreg(3, 8'h06); rchk(3, 8'h40, 8'h40, "R4 no prior read");
      wreg(3, 8'h06); rchk(3, 8'h00, 8'h40, "R4 read then write 0");
      wreg(3, 8'h66); rchk(3, 8'h00, 8'h60, "R5 write one");
      // R9: same-cycle matches
      wreg(0, 0); wreg(1, 3); wreg(2, 3); wreg(3, 8'h09);
      idle(5, 1); idle(1, 0); #1 check("R9 B high beats A low", tmr_out, 1);
      wreg(0, 0); wreg(3, 8'h0F);
      idle(5, 1); idle(1, 0); #1 check("R9 both invert once", tmr_out, 0);
      wreg(0, 0); wreg(3, 8'h07);
      idle(5, 1); idle(1, 0); #1 check("R9 invert beats drive", tmr_out, 1);
      // R10: disabled pin, state kept
      wreg(3, 8'h00); idle(1, 0); #1 check("R10 disabled pin", tmr_out, 0);
      wreg(3, 8'h0C); idle(1, 0); #1 check("R10 level kept", tmr_out, 1);
      // R3 R12: wrap and interrupts
      wreg(4, 3); wreg(1, 0); wreg(0, 8'hFD);
      idle(4, 1); idle(1, 0);
      #1 check("R3 R12 wrap irq", irq_w, 1);
      check("R2 R12 match irq", irq_a, 1);
      wreg(4, 0); idle(1, 0); #1 check("R12 masked", irq_a | irq_w, 0);
      wreg(4, 3);
      // R6: hardware set wins over clearing write
      rchk(3, 8'h60, 8'h60, "R6 flags set");
      wreg(0, 8'h10); wreg(1, 8'h10);
      op(1, 1, 0, 3, 8'h00);
      rchk(3, 8'h40, 8'h40, "R6 set wins");
      wreg(3, 8'h00); rchk(3, 8'h00, 8'h60, "R4 cleared after race");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int k, a;
         k = $urandom_range(0, 19);
         a = $urandom_range(0, 5);
         if (k < 12)      op(1, 0, 0, 0, 0);
         else if (k < 16) op($urandom_range(0, 1), 0, 1, a, 0);
         else if (k < 19) op($urandom_range(0, 1), 1, 0, (a == 0) ? 3 : a, $urandom_range(0, 255));
         else             op(1, 1, 0, 0, $urandom_range(0, 255));
      end
      idle(2, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule